// File: doc/BRIEF.md
# SDRAM Open-Row Bank Command Sequencer

This block sits between user logic and an SDRAM-style command bus. User logic offers one read or write request at a time through a ready/valid handshake. Each request carries a bank, a row and a column address. The block turns each request into the commands the memory needs. It drives these on three active-low strobes (row strobe, column strobe, write enable), a 13-bit address bus shared between row and column addresses, and a 2-bit bank bus.

The block keeps track of one open row in each of the four banks. When a request targets the row that is already open in its bank, only the column command is issued. A request to a closed bank first activates the row. A request to a different row in a bank that already has an open row first closes that row with a precharge, then activates the new row. The minimum spacing from precharge to activate and from activate to column command is set by parameters and counted in clock cycles. The block fills those gaps with no-operation commands. While such a sequence runs, the block withholds ready.

All command outputs come from registers and change on the rising clock edge. Refresh, data transfer and clock generation are handled elsewhere.

Top module: `sdram_row_sequencer`

## Requirements
- R1: During and directly after reset, the command bus shows a no-operation, the address and bank buses are zero and req_ready is high.
- R2: Command encodings on {ras_n, cas_n, we_n}: no-operation 111, activate 011, read 101, write 100, precharge 010. The address bus carries the row for activate, the column zero-extended (upper three bits zero) for read and write, and zero for precharge and no-operation. The bank bus is zero during no-operation.
- R3: After reset every bank counts as closed. The first request to a bank issues an activate and never a precharge.
- R4: A request whose row matches the open row of its bank issues only its column command, with no activate and no precharge, and req_ready stays high.
- R5: A request to a bank whose open row differs issues a precharge, then an activate of the new row, then the column command.
- R6: The column command follows its activate by exactly T_RCD cycles, with no-operations in between.
- R7: The activate follows its precharge by exactly T_RP cycles, with no-operations in between.
- R8: req_ready is low from the cycle after a miss is accepted until the cycle in which its column command is shown. A request held valid while ready is low is not taken and has no effect on the bus.
- R9: Each bank keeps its own open row. Opening or closing a row in one bank does not change which row counts as open in another bank.
- R10: Every command of a request's sequence drives that request's bank on the bank bus.
- R11: A request is taken on a clock edge where req_valid and req_ready are both high. Its first command appears on the bus in the cycle right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands are launched on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 2 | Target bank |
| req_row | input | 13 | Target row |
| req_col | input | 10 | Target column |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_addr | output | 13 | Shared row/column address |
| cmd_bank | output | 2 | Bank select |

## Verification
The bench builds the block with T_RCD = 3 and T_RP = 2. Because the two gaps differ and both exceed one cycle, a swapped or off-by-one counter shows up as a mistimed activate or column command, and no-operation filler cycles appear in both waits. The default 2-bit bank and 13-bit row widths let the bench reach all four banks and the extreme row and column values. A small set of rows per bank makes hits, misses to closed banks and misses to open banks all occur many times.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

  // Encoding is {ras_n, cas_n, we_n}
  typedef enum logic [2:0] {
    CMD_NOP = 3'b111,
    CMD_ACT = 3'b011,
    CMD_RD  = 3'b101,
    CMD_WR  = 3'b100,
    CMD_PRE = 3'b010
  } sdr_cmd_e;

  typedef enum logic [1:0] {
    SQ_IDLE     = 2'd0,
    SQ_PRE_WAIT = 2'd1,
    SQ_ACT_WAIT = 2'd2
  } seq_state_e;

endpackage

// File: rtl/sdr_bank_table.sv
module sdr_bank_table #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] look_bank,
  input  logic [ROW_W-1:0]  look_row,
  output logic              look_open,
  output logic              look_hit,
  input  logic              set_en,
  input  logic              clr_en,
  input  logic [BANK_W-1:0] upd_bank,
  input  logic [ROW_W-1:0]  upd_row
);

  localparam int BANKS = 1 << BANK_W;

  logic             valid_q [BANKS];
  logic [ROW_W-1:0] row_q   [BANKS];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic sel;
    logic valid_d;
    assign sel = (upd_bank == BANK_W'(b));

    always_comb begin
      valid_d = valid_q[b];
      if (sel && set_en) valid_d = 1'b1;
      if (sel && clr_en) valid_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[b] <= 1'b0;
        row_q[b]   <= '0;
      end else begin
        valid_q[b] <= valid_d;
        if (sel && set_en) row_q[b] <= upd_row;
      end
    end
  end

  assign look_open = valid_q[look_bank];
  assign look_hit  = valid_q[look_bank] && (row_q[look_bank] == look_row);

  // R3
  set_clr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_en && clr_en));

endmodule

// File: rtl/sdr_gap_timer.sv
module sdr_gap_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)               cnt_d = load_val;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/sdr_cmd_reg.sv
module sdr_cmd_reg
  import sdr_seq_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sdr_cmd_e          nxt_cmd,
  input  logic [ADDR_W-1:0] nxt_addr,
  input  logic [BANK_W-1:0] nxt_bank,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] bank
);

  sdr_cmd_e          cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BANK_W-1:0] bank_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= CMD_NOP;
      addr_q <= '0;
      bank_q <= '0;
    end else begin
      cmd_q  <= nxt_cmd;
      addr_q <= nxt_addr;
      bank_q <= nxt_bank;
    end
  end

  assign {ras_n, cas_n, we_n} = cmd_q;
  assign addr = addr_q;
  assign bank = bank_q;

endmodule

// File: rtl/sdram_row_sequencer.sv
module sdram_row_sequencer
  import sdr_seq_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int T_RCD  = 2,
  parameter int T_RP   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  output logic              cmd_ras_n,
  output logic              cmd_cas_n,
  output logic              cmd_we_n,
  output logic [ROW_W-1:0]  cmd_addr,
  output logic [BANK_W-1:0] cmd_bank
);

  localparam int ADDR_W  = ROW_W;
  localparam int GAP_MAX = (T_RCD > T_RP) ? T_RCD : T_RP;
  localparam int CNT_W   = (GAP_MAX < 2) ? 1 : $clog2(GAP_MAX);
  localparam logic [CNT_W-1:0] RCD_LOAD = CNT_W'(T_RCD - 1);
  localparam logic [CNT_W-1:0] RP_LOAD  = CNT_W'(T_RP - 1);

  seq_state_e state_q, state_d;

  logic              pend_wr_q;
  logic [BANK_W-1:0] pend_bank_q;
  logic [ROW_W-1:0]  pend_row_q;
  logic [COL_W-1:0]  pend_col_q;

  logic accept;
  logic latch_en;
  logic row_open, row_hit;
  logic set_en, clr_en;
  logic [BANK_W-1:0] upd_bank;
  logic [ROW_W-1:0]  upd_row;
  logic tmr_load, tmr_done;
  logic [CNT_W-1:0] tmr_val;

  sdr_cmd_e          nxt_cmd;
  logic [ADDR_W-1:0] nxt_addr;
  logic [BANK_W-1:0] nxt_bank;

  assign req_ready = (state_q == SQ_IDLE);
  assign accept    = req_valid && req_ready;

  assign upd_bank = (state_q == SQ_IDLE) ? req_bank : pend_bank_q;
  assign upd_row  = (state_q == SQ_IDLE) ? req_row  : pend_row_q;

  sdr_bank_table #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .look_bank (req_bank),
    .look_row  (req_row),
    .look_open (row_open),
    .look_hit  (row_hit),
    .set_en    (set_en),
    .clr_en    (clr_en),
    .upd_bank  (upd_bank),
    .upd_row   (upd_row)
  );

  sdr_gap_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  sdr_cmd_reg #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_cmd (
    .clk      (clk),
    .rst_n    (rst_n),
    .nxt_cmd  (nxt_cmd),
    .nxt_addr (nxt_addr),
    .nxt_bank (nxt_bank),
    .ras_n    (cmd_ras_n),
    .cas_n    (cmd_cas_n),
    .we_n     (cmd_we_n),
    .addr     (cmd_addr),
    .bank     (cmd_bank)
  );

  // Next-state and command selection
  always_comb begin
    state_d  = state_q;
    nxt_cmd  = CMD_NOP;
    nxt_addr = '0;
    nxt_bank = '0;
    set_en   = 1'b0;
    clr_en   = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    latch_en = 1'b0;
    case (state_q)
      SQ_IDLE: begin
        if (accept) begin
          latch_en = 1'b1;
          nxt_bank = req_bank;
          if (row_hit) begin
            nxt_cmd  = req_write ? CMD_WR : CMD_RD;
            nxt_addr = ADDR_W'(req_col);
          end else if (row_open) begin
            nxt_cmd  = CMD_PRE;
            clr_en   = 1'b1;
            tmr_load = 1'b1;
            tmr_val  = RP_LOAD;
            state_d  = SQ_PRE_WAIT;
          end else begin
            nxt_cmd  = CMD_ACT;
            nxt_addr = req_row;
            set_en   = 1'b1;
            tmr_load = 1'b1;
            tmr_val  = RCD_LOAD;
            state_d  = SQ_ACT_WAIT;
          end
        end
      end
      SQ_PRE_WAIT: begin
        if (tmr_done) begin
          nxt_cmd  = CMD_ACT;
          nxt_addr = pend_row_q;
          nxt_bank = pend_bank_q;
          set_en   = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = RCD_LOAD;
          state_d  = SQ_ACT_WAIT;
        end
      end
      SQ_ACT_WAIT: begin
        if (tmr_done) begin
          nxt_cmd  = pend_wr_q ? CMD_WR : CMD_RD;
          nxt_addr = ADDR_W'(pend_col_q);
          nxt_bank = pend_bank_q;
          state_d  = SQ_IDLE;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= SQ_IDLE;
      pend_wr_q   <= 1'b0;
      pend_bank_q <= '0;
      pend_row_q  <= '0;
      pend_col_q  <= '0;
    end else begin
      state_q <= state_d;
      if (latch_en) begin
        pend_wr_q   <= req_write;
        pend_bank_q <= req_bank;
        pend_row_q  <= req_row;
        pend_col_q  <= req_col;
      end
    end
  end

  // Observed command on the bus
  logic [2:0] bus_cmd;
  logic bus_nop, bus_act, bus_pre, bus_col;
  assign bus_cmd = {cmd_ras_n, cmd_cas_n, cmd_we_n};
  assign bus_nop = (bus_cmd == 3'b111);
  assign bus_act = (bus_cmd == 3'b011);
  assign bus_pre = (bus_cmd == 3'b010);
  assign bus_col = (bus_cmd == 3'b101) || (bus_cmd == 3'b100);

  // R2
  cmd_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_nop || bus_act || bus_pre || bus_col);

  // R6
  act_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_act |=> ((T_RCD > 1) ? bus_nop : bus_col));

  // R7
  pre_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_pre |=> ((T_RP > 1) ? bus_nop : bus_act));

  // R4
  hit_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && row_hit) |=> (bus_col && cmd_bank == $past(req_bank)));

endmodule

// File: tb/sdram_row_sequencer_test.sv
module sdram_row_sequencer_test;

  localparam int CLK_PERIOD = 10;
  localparam int T_RCD = 3;
  localparam int T_RP  = 2;

  localparam logic [2:0] C_NOP = 3'b111;
  localparam logic [2:0] C_ACT = 3'b011;
  localparam logic [2:0] C_RD  = 3'b101;
  localparam logic [2:0] C_WR  = 3'b100;
  localparam logic [2:0] C_PRE = 3'b010;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic [1:0]  req_bank = '0;
  logic [12:0] req_row = '0;
  logic [9:0]  req_col = '0;
  logic req_ready;
  logic cmd_ras_n, cmd_cas_n, cmd_we_n;
  logic [12:0] cmd_addr;
  logic [1:0]  cmd_bank;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_row_sequencer #(.T_RCD(T_RCD), .T_RP(T_RP)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .cmd_ras_n(cmd_ras_n), .cmd_cas_n(cmd_cas_n), .cmd_we_n(cmd_we_n),
    .cmd_addr(cmd_addr), .cmd_bank(cmd_bank)
  );

  typedef struct packed {
    logic [2:0]  c;
    logic [12:0] a;
    logic [1:0]  b;
  } exp_t;

  int vectors = 0;
  int fails = 0;

  task automatic check(input string tag, input logic ok, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  exp_t q[$];
  exp_t cur;
  logic exp_ready;
  logic model_acc;
  logic        m_valid [4];
  logic [12:0] m_row   [4];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      cur = '{c: C_NOP, a: 13'd0, b: 2'd0};
      exp_ready = 1'b1;
      model_acc = 1'b0;
      for (int i = 0; i < 4; i++) begin m_valid[i] = 1'b0; m_row[i] = '0; end
    end else begin
      model_acc = req_valid && (q.size() == 0);
      if (model_acc) begin
        exp_t col_e;
        col_e = '{c: (req_write ? C_WR : C_RD), a: {3'b000, req_col}, b: req_bank};
        if (!(m_valid[req_bank] && m_row[req_bank] == req_row)) begin
          if (m_valid[req_bank]) begin
            q.push_back('{c: C_PRE, a: 13'd0, b: req_bank});
            for (int i = 1; i < T_RP; i++) q.push_back('{c: C_NOP, a: 13'd0, b: 2'd0});
          end
          q.push_back('{c: C_ACT, a: req_row, b: req_bank});
          for (int i = 1; i < T_RCD; i++) q.push_back('{c: C_NOP, a: 13'd0, b: 2'd0});
          m_valid[req_bank] = 1'b1;
          m_row[req_bank] = req_row;
        end
        q.push_back(col_e);
      end
      if (q.size() != 0) cur = q.pop_front();
      else cur = '{c: C_NOP, a: 13'd0, b: 2'd0};
      exp_ready = (q.size() == 0);
    end
  end

  // Observed command counters and cycle stamps
  int n_act = 0, n_pre = 0, cyc = 0;
  int last_act_cyc = 0, last_pre_cyc = 0, last_col_cyc = 0;

  always @(negedge clk) begin
    string tag;
    logic [2:0] got;
    cyc++;
    got = {cmd_ras_n, cmd_cas_n, cmd_we_n};
    if (got == C_ACT) begin n_act++; last_act_cyc = cyc; end
    if (got == C_PRE) begin n_pre++; last_pre_cyc = cyc; end
    if (got == C_RD || got == C_WR) last_col_cyc = cyc;
    if (!rst_n) tag = "R1";
    else case (cur.c)
      C_ACT:       tag = "R3";
      C_PRE:       tag = "R5";
      C_RD, C_WR:  tag = "R6";
      default:     tag = "R2";
    endcase
    check(tag, got == cur.c, 32'(got), 32'(cur.c));
    check("R2", cmd_addr == cur.a, 32'(cmd_addr), 32'(cur.a));
    check("R10", cmd_bank == cur.b, 32'(cmd_bank), 32'(cur.b));
    check(rst_n ? "R8" : "R1", req_ready == exp_ready, 32'(req_ready), 32'(exp_ready));
  end

  task automatic send(input logic w, input logic [1:0] b, input logic [12:0] r, input logic [9:0] c);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_bank = b; req_row = r; req_col = c;
    do begin @(posedge clk); #1; end while (!model_acc);
    req_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (T_RCD + T_RP + 4) @(negedge clk);
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
  end

  initial begin
    int a0, p0;
    int unsigned seed;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", {cmd_ras_n, cmd_cas_n, cmd_we_n} == C_NOP && req_ready, 32'({cmd_ras_n, cmd_cas_n, cmd_we_n}), 32'(C_NOP));
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", cmd_addr == 0 && cmd_bank == 0, 32'(cmd_addr), 0);

    // R3: first access to each closed bank activates without precharge
    send(1'b0, 2'd0, 13'd5, 10'd1);
    send(1'b1, 2'd1, 13'd6, 10'd2);
    send(1'b0, 2'd2, 13'd7, 10'd3);
    send(1'b1, 2'd3, 13'd8, 10'd4);
    settle();
    check("R3", n_pre == 0, 32'(n_pre), 0);
    check("R3", n_act == 4, 32'(n_act), 4);
    check("R6", last_col_cyc - last_act_cyc == T_RCD, 32'(last_col_cyc - last_act_cyc), 32'(T_RCD));

    // R4 / R11: hits issue only the column command, the cycle after acceptance
    a0 = n_act; p0 = n_pre;
    for (int i = 0; i < 4; i++) begin
      send(i[0], 2'd0, 13'd5, 10'(100 + i));
      @(negedge clk);
      check("R11", {cmd_ras_n, cmd_cas_n} == 2'b10 && cmd_addr == 13'(100 + i),
            32'(cmd_addr), 32'(100 + i));
    end
    check("R4", n_act == a0 && n_pre == p0, 32'(n_act - a0 + n_pre - p0), 0);

    // R5 / R7: miss on an open bank
    send(1'b1, 2'd0, 13'd9, 10'd11);
    settle();
    check("R5", n_pre == p0 + 1 && n_act == a0 + 1, 32'(n_pre - p0), 1);
    check("R7", last_act_cyc - last_pre_cyc == T_RP, 32'(last_act_cyc - last_pre_cyc), 32'(T_RP));
    check("R6", last_col_cyc - last_act_cyc == T_RCD, 32'(last_col_cyc - last_act_cyc), 32'(T_RCD));

    // R9: bank 1 still holds its row after bank 0 changed
    a0 = n_act;
    send(1'b0, 2'd1, 13'd6, 10'd7);
    settle();
    check("R9", n_act == a0, 32'(n_act - a0), 0);

    // R8: request held while ready is low is not taken early
    send(1'b0, 2'd2, 13'd20, 10'd1);
    send(1'b1, 2'd3, 13'd21, 10'd2);
    settle();

    // Extreme address values
    send(1'b1, 2'd3, 13'h1FFF, 10'h3FF);
    send(1'b0, 2'd3, 13'h1FFF, 10'h000);
    settle();

    // Mixed traffic over a small row set
    seed = 32'h1234_5678;
    for (int i = 0; i < 400; i++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      send(seed[20], seed[17:16], 13'(seed[25:24]), 10'(seed[31:22]));
      if (seed[5:4] == 2'b00) repeat (int'(seed[9:8])) @(negedge clk);
    end
    settle();
    report();
  end

endmodule